// File: doc/BRIEF.md
# Bidirectional Preset Counter with Wrap and Parity Flags

This block holds a 9-bit count that changes only on the rising clock edge. Two independent control pins choose what happens at each edge. One pin steps the count upward and the other steps it downward. Raising both pins presets the count from a parallel data word. Leaving both low freezes the count.

Beside the count, the block reports three status bits. A carry bit marks the cycle in which an upward step rolls over from the top value to zero. A borrow bit marks the cycle in which a downward step rolls under from zero to the top value. A parity bit shows whether the count currently holds an odd number of ones.

The count has no reset. Its value at power-up is unknown, so the user presets it once before relying on it. The interface carries no data stream, so every pin is a plain level signal with no handshake or back-pressure.

Top module: `updn_counter`

## Requirements
- R1: The count and the carry and borrow flags change only at a rising clock edge; between edges they keep their values.
- R2: With up=1 and down=0 at an edge, the count becomes the previous count plus one, modulo 512.
- R3: With up=0 and down=1 at an edge, the count becomes the previous count minus one, modulo 512.
- R4: With up=1 and down=1 at an edge, the count takes the value of data_in sampled at that edge.
- R5: With up=0 and down=0 at an edge, the count keeps its value.
- R6: An upward step from 511 gives count 0 with carry_out=1 for that one cycle; the next edge clears carry_out unless it wraps again.
- R7: A downward step from 0 gives count 511 with borrow_out=1 for that one cycle; the next edge clears borrow_out unless it wraps again.
- R8: After a load edge, a hold edge or a step that does not wrap, both carry_out and borrow_out are 0, and the two flags are never 1 together.
- R9: parity_out equals the XOR of all nine count bits (1 for an odd number of ones) and follows the registered count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| data_in | input | 9 | Preset value, taken when up and down are both high |
| up | input | 1 | Upward step request |
| down | input | 1 | Downward step request |
| count | output | 9 | Registered count |
| carry_out | output | 1 | High for one cycle after an upward rollover to zero |
| borrow_out | output | 1 | High for one cycle after a downward rollunder to 511 |
| parity_out | output | 1 | XOR reduction of the count |

## Verification
After the first preset, the bound assertions check every cycle that each control combination gives the right next count. They also check that each wrap raises its flag, that load and hold edges clear both flags, that the two flags never coincide, and that a hold leaves parity unchanged. Only the bench can show that the parity value itself is correct for arbitrary counts and that nothing moves between clock edges. Its scenarios also cover rollovers reached after long random runs and back-to-back direction reversals right at the wrap points.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_DEC  = 2'b01,
    MODE_INC  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/updn_mode_dec.sv
module updn_mode_dec
  import updn_pkg::*;
(
  input  logic  up,
  input  logic  down,
  output mode_e mode
);
  always_comb begin
    unique case ({up, down})
      2'b11:   mode = MODE_LOAD;
      2'b10:   mode = MODE_INC;
      2'b01:   mode = MODE_DEC;
      default: mode = MODE_HOLD;
    endcase
  end
endmodule

// File: rtl/updn_step.sv
module updn_step
  import updn_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  mode_e            mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt,
  output logic             wrap_hi,
  output logic             wrap_lo
);
  localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  always_comb begin
    nxt     = cur;
    wrap_hi = 1'b0;
    wrap_lo = 1'b0;
    unique case (mode)
      MODE_LOAD: nxt = preset;
      MODE_INC: begin
        nxt     = cur + ONE;
        wrap_hi = (cur == TOP);
      end
      MODE_DEC: begin
        nxt     = cur - ONE;
        wrap_lo = (cur == ZERO);
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/updn_parity.sv
module updn_parity #(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] value,
  output logic             odd
);
  logic [WIDTH-1:0] chain;

  assign chain[0] = value[0];
  for (genvar i = 1; i < WIDTH; i++) begin : g_chain
    assign chain[i] = chain[i-1] ^ value[i];
  end
  assign odd = chain[WIDTH-1];
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] data_in,
  input  logic             up,
  input  logic             down,
  output logic [WIDTH-1:0] count,
  output logic             carry_out,
  output logic             borrow_out,
  output logic             parity_out
);
  mode_e            mode;
  logic [WIDTH-1:0] nxt;
  logic             wrap_hi;
  logic             wrap_lo;

  updn_mode_dec u_dec (
    .up   (up),
    .down (down),
    .mode (mode)
  );

  updn_step #(.WIDTH(WIDTH)) u_step (
    .mode    (mode),
    .cur     (count),
    .preset  (data_in),
    .nxt     (nxt),
    .wrap_hi (wrap_hi),
    .wrap_lo (wrap_lo)
  );

  always_ff @(posedge clk) begin
    count      <= nxt;
    carry_out  <= wrap_hi;
    borrow_out <= wrap_lo;
  end

  updn_parity #(.WIDTH(WIDTH)) u_par (
    .value (count),
    .odd   (parity_out)
  );
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic [WIDTH-1:0] data_in,
  input logic             up,
  input logic             down,
  input logic [WIDTH-1:0] count,
  input logic             carry_out,
  input logic             borrow_out,
  input logic             parity_out
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  // Count is unknown until the first preset; checks start after it.
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (up && down) armed <= 1'b1;
  end

  p_load_r4: assert property (@(posedge clk) disable iff (!armed)
    (up && down) |=> (count == $past(data_in)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!armed)
    (!up && !down) |=> $stable(count));

  p_inc_r2: assert property (@(posedge clk) disable iff (!armed)
    (up && !down) |=> (count == WIDTH'($past(count) + WIDTH'(1))));

  p_dec_r3: assert property (@(posedge clk) disable iff (!armed)
    (!up && down) |=> (count == WIDTH'($past(count) - WIDTH'(1))));

  p_carry_wrap_r6: assert property (@(posedge clk) disable iff (!armed)
    (up && !down && count == TOP) |=> (carry_out && count == '0));

  p_borrow_wrap_r7: assert property (@(posedge clk) disable iff (!armed)
    (!up && down && count == '0) |=> (borrow_out && count == TOP));

  p_flags_clear_r8: assert property (@(posedge clk) disable iff (!armed)
    (up == down) |=> (!carry_out && !borrow_out));

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!armed)
    $onehot0({carry_out, borrow_out}));

  p_parity_hold_r9: assert property (@(posedge clk) disable iff (!armed)
    (!up && !down) |=> $stable(parity_out));
endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/updn_counter_bench.sv
module updn_counter_bench;
  localparam int W = 9;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         clk = 1'b0;
  logic [W-1:0] data_in = 9'd0;
  logic         up = 1'b1;
  logic         down = 1'b1;
  logic [W-1:0] count;
  logic         carry_out, borrow_out, parity_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_count;
  logic         exp_carry, exp_borrow;

  always #4 clk = ~clk;

  updn_counter #(.WIDTH(W)) u_updn_counter (
    .clk(clk), .data_in(data_in), .up(up), .down(down),
    .count(count), .carry_out(carry_out), .borrow_out(borrow_out),
    .parity_out(parity_out)
  );

  function automatic logic [W-1:0] model_next(logic u, logic d, logic [W-1:0] c, logic [W-1:0] p);
    if (u && d) return p;
    if (u) return W'(c + 1);
    if (d) return W'(c - 1);
    return c;
  endfunction

  function automatic logic model_par(logic [W-1:0] v);
    logic r = 1'b0;
    for (int i = 0; i < W; i++) r = r ^ v[i];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk(count == exp_count, {tag, " count"}, count, exp_count);
    chk(carry_out == exp_carry, "R6 carry_out", carry_out, exp_carry);
    chk(borrow_out == exp_borrow, "R7 borrow_out", borrow_out, exp_borrow);
    chk(!(carry_out && borrow_out), "R8 flags exclusive", {carry_out, borrow_out}, 0);
    chk(parity_out == model_par(count), "R9 parity", parity_out, model_par(count));
  endtask

  // Called at a negedge: drive, advance model, wait a full cycle, check.
  task automatic step(logic u, logic d, logic [W-1:0] p, string tag);
    up = u; down = d; data_in = p;
    exp_carry  = u && !d && exp_count == TOP;
    exp_borrow = !u && d && exp_count == '0;
    exp_count  = model_next(u, d, exp_count, p);
    @(posedge clk);
    #2;
    // R1: settled shortly after the edge, must not move until the next edge
    chk(count == exp_count, "R1 post-edge count", count, exp_count);
    @(negedge clk);
    chk(count == exp_count, "R1 stable between edges", count, exp_count);
    check_all(tag);
  endtask

  initial begin
    logic [W-1:0] r;
    void'($urandom(32'd20240611));
    exp_count = 9'd0; exp_carry = 0; exp_borrow = 0;
    @(negedge clk);
    // First preset establishes a known count (R4)
    step(1, 1, 9'd510, "R4 load");
    step(1, 0, 9'd0,   "R2 inc");
    step(1, 0, 9'd0,   "R6 wrap up");       // 511 -> 0, carry
    step(1, 0, 9'd0,   "R6 carry clears");
    step(0, 1, 9'd0,   "R3 dec");            // 1 -> 0
    step(0, 1, 9'd0,   "R7 wrap down");      // 0 -> 511, borrow
    step(0, 0, 9'd7,   "R5 hold");           // borrow cleared, R8
    step(1, 0, 9'd0,   "R6 reverse at top"); // 511 -> 0 carry
    step(0, 1, 9'd0,   "R7 reverse at zero");// 0 -> 511 borrow
    step(1, 0, 9'd0,   "R6 back to top");    // 511 -> 0 carry
    step(1, 1, 9'd0,   "R8 load clears");
    step(0, 1, 9'd0,   "R7 wrap after load");
    step(1, 1, 9'd511, "R4 load top");
    step(1, 1, 9'd171, "R8 load after load");
    step(0, 0, 9'd0,   "R5 hold value");
    step(0, 0, 9'd3,   "R5 hold again");
    for (int k = 0; k < 6; k++) step(k[0], !k[0], 9'd0, "R2 R3 alternate");
    // Random phase with bias toward near-wrap presets
    for (int n = 0; n < 3000; n++) begin
      int sel = int'($urandom_range(0, 9));
      r = W'($urandom);
      if ($urandom_range(0, 3) == 0) r = ($urandom_range(0, 1) != 0) ? TOP - W'($urandom_range(0, 2)) : W'($urandom_range(0, 2));
      if (sel < 4)      step(1, 0, r, "R2 rand inc");
      else if (sel < 8) step(0, 1, r, "R3 rand dec");
      else if (sel < 9) step(1, 1, r, "R4 rand load");
      else              step(0, 0, r, "R5 rand hold");
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule